// File: doc/BRIEF.md
# NAND Chunk ECC Syndrome Checker

This block compares two 22-bit Hamming check codes belonging to one 256-byte NAND data chunk. One code is computed over the data as it was read. The other was stored in the spare area when the chunk was written. From their XOR syndrome the block decides the outcome:

- the data is clean,
- the check code itself took a hit,
- a single data bit flipped and can be repaired at a reported byte and bit, or
- the damage is beyond repair.

Patching the buffer is left to the consumer of the result. Generating the codes is also outside this block.

Each 22-bit code holds eleven parity bits in its low half. Its high half holds the eleven complementary parities. Byte 0 of the code sits in bits [7:0], byte 1 in bits [15:8], and the six used bits of byte 2 in bits [21:16].

A request is accepted over a valid/ready pair. The result appears on a registered valid/ready output one cycle later. In pair mode the block covers a 512-byte chunk. It checks two code pairs, one per 256-byte half, and returns two results in order. The second result is flagged as last and carries the combined failure flag.

Top module: `ecc_syndrome_check`

## Requirements
- R1: Half h of the request (h = 0 or 1) uses calc_i[22h+21:22h] and stored_i[22h+21:22h]. Bits [10:0] of a code are its parity set and bits [21:11] its complementary set.
- R2: Status 2'b00 (clean) is reported when the two codes are equal, or when either code is all zeros.
- R3: Status 2'b01 (check-code error) is reported when exactly one syndrome bit is set.
- R4: Status 2'b10 (correctable) is reported when two conditions hold. First, exactly eleven syndrome bits are set. Second, (calc low XOR calc high) XOR (stored low XOR stored high) equals 11'h7FF. In that case bit_idx_o equals syndrome[2:0] and the low eight bits of byte_idx_o equal syndrome[10:3].
- R5: Every other nonzero syndrome with both codes nonzero gives status 2'b11 (uncorrectable).
- R6: byte_idx_o and bit_idx_o are zero whenever the status is not 2'b10.
- R7: out_valid_o rises in the cycle after a request is accepted. in_ready_o is low while any result is still pending. Result fields stay stable while out_ready_i is low. A request offered while busy is dropped.
- R8: With pair_mode_i low, exactly one result is returned, from half 0, with last_o high. fail_o is high when the status is 01 or 11. The half-1 codes have no effect.
- R9: With pair_mode_i high, two results are returned. The first comes from half 0 with last_o low. The second comes from half 1 with last_o high, and a correctable location there has 256 added to byte_idx_o.
- R10: In pair mode, the first result's fail_o reflects half 0 only. The second result's fail_o is the OR of both halves' failures.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Block can take a request |
| pair_mode_i | input | 1 | 1: 512-byte chunk, two halves; 0: 256-byte chunk |
| calc_i | input | 44 | Computed codes, half 0 in [21:0], half 1 in [43:22] |
| stored_i | input | 44 | Stored codes, same layout |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Consumer takes result |
| status_o | output | 2 | 00 clean, 01 check-code error, 10 correctable, 11 uncorrectable |
| byte_idx_o | output | 9 | Failing byte within the chunk |
| bit_idx_o | output | 3 | Failing bit within the byte |
| last_o | output | 1 | Final result of the request |
| fail_o | output | 1 | Accumulated failure flag |

## Verification
The correctable verdict needs a syndrome with exactly eleven set bits whose two halves are bitwise complements. Random code pairs essentially never produce one. The bench therefore builds the computed code as the stored code XOR {~p, p} and sweeps every 11-bit location p.

The near-miss cases are built the same way: eleven set bits that are not complementary, and every single-bit and two-bit syndrome.

Pair mode is driven with mixed verdicts per half, including a failing first half followed by a clean second half. This shows that the failure flag carries across beats.

// File: rtl/ecc_chk_pkg.sv
package ecc_chk_pkg;
  localparam int unsigned DEF_HALF_W = 11;

  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_CODE  = 2'b01,
    ST_FIXED = 2'b10,
    ST_BAD   = 2'b11
  } ecc_status_e;

  function automatic logic is_fail(ecc_status_e s);
    return (s == ST_CODE) || (s == ST_BAD);
  endfunction
endpackage

// File: rtl/ecc_popcount.sv
module ecc_popcount #(
  parameter int unsigned W = 22,
  localparam int unsigned CNT_W = $clog2(W + 1)
) (
  input  logic [W-1:0]     vec_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + CNT_W'(vec_i[i]);
  end
endmodule

// File: rtl/ecc_half_classify.sv
module ecc_half_classify
  import ecc_chk_pkg::*;
#(
  parameter int unsigned HALF_W = DEF_HALF_W,
  localparam int unsigned CODE_W = 2 * HALF_W,
  localparam int unsigned OFF_W  = HALF_W - 3,
  localparam int unsigned CNT_W  = $clog2(CODE_W + 1)
) (
  input  logic [CODE_W-1:0] calc_i,
  input  logic [CODE_W-1:0] stored_i,
  output ecc_status_e       status_o,
  output logic [OFF_W-1:0]  byte_o,
  output logic [2:0]        bit_o
);
  logic [CODE_W-1:0] syn;
  logic [CNT_W-1:0]  syn_pop;
  logic [HALF_W-1:0] cmp_chk;

  assign syn     = calc_i ^ stored_i;
  assign cmp_chk = (calc_i[HALF_W-1:0] ^ calc_i[CODE_W-1:HALF_W])
                 ^ (stored_i[HALF_W-1:0] ^ stored_i[CODE_W-1:HALF_W]);

  ecc_popcount #(.W(CODE_W)) u_pop (.vec_i(syn), .cnt_o(syn_pop));

  always_comb begin
    status_o = ST_BAD;
    byte_o   = '0;
    bit_o    = '0;
    if (syn == '0 || calc_i == '0 || stored_i == '0) begin
      status_o = ST_CLEAN;
    end else if (syn_pop == CNT_W'(1)) begin
      status_o = ST_CODE;
    end else if (syn_pop == CNT_W'(HALF_W) && cmp_chk == '1) begin
      status_o = ST_FIXED;
      byte_o   = syn[HALF_W-1:3];
      bit_o    = syn[2:0];
    end
  end
endmodule

// File: rtl/ecc_syndrome_check.sv
module ecc_syndrome_check
  import ecc_chk_pkg::*;
#(
  parameter int unsigned HALF_W     = DEF_HALF_W,
  parameter int unsigned NUM_HALVES = 2,
  localparam int unsigned CODE_W = 2 * HALF_W,
  localparam int unsigned IN_W   = NUM_HALVES * CODE_W,
  localparam int unsigned OFF_W  = HALF_W - 3,
  localparam int unsigned BEAT_W = $clog2(NUM_HALVES),
  localparam int unsigned IDX_W  = OFF_W + BEAT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic             pair_mode_i,
  input  logic [IN_W-1:0]  calc_i,
  input  logic [IN_W-1:0]  stored_i,
  output logic             out_valid_o,
  input  logic             out_ready_i,
  output logic [1:0]       status_o,
  output logic [IDX_W-1:0] byte_idx_o,
  output logic [2:0]       bit_idx_o,
  output logic             last_o,
  output logic             fail_o
);
  ecc_status_e      st_d [NUM_HALVES];
  logic [OFF_W-1:0] by_d [NUM_HALVES];
  logic [2:0]       bi_d [NUM_HALVES];
  ecc_status_e      st_q [NUM_HALVES];
  logic [OFF_W-1:0] by_q [NUM_HALVES];
  logic [2:0]       bi_q [NUM_HALVES];

  logic              valid_q, fail_acc_q;
  logic [BEAT_W-1:0] beat_q, last_beat_q;
  logic              accept, take, cur_fail;
  ecc_status_e       cur_st;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    ecc_half_classify #(.HALF_W(HALF_W)) u_cls (
      .calc_i  (calc_i[h*CODE_W +: CODE_W]),
      .stored_i(stored_i[h*CODE_W +: CODE_W]),
      .status_o(st_d[h]),
      .byte_o  (by_d[h]),
      .bit_o   (bi_d[h])
    );
  end

  assign in_ready_o = !valid_q;
  assign accept     = in_valid_i && in_ready_o;
  assign take       = valid_q && out_ready_i;
  assign cur_st     = st_q[beat_q];
  assign cur_fail   = is_fail(cur_st);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q     <= 1'b0;
      fail_acc_q  <= 1'b0;
      beat_q      <= '0;
      last_beat_q <= '0;
      for (int h = 0; h < NUM_HALVES; h++) begin
        st_q[h] <= ST_CLEAN;
        by_q[h] <= '0;
        bi_q[h] <= '0;
      end
    end else if (accept) begin
      valid_q     <= 1'b1;
      fail_acc_q  <= 1'b0;
      beat_q      <= '0;
      last_beat_q <= pair_mode_i ? BEAT_W'(NUM_HALVES - 1) : '0;
      for (int h = 0; h < NUM_HALVES; h++) begin
        st_q[h] <= st_d[h];
        by_q[h] <= by_d[h];
        bi_q[h] <= bi_d[h];
      end
    end else if (take) begin
      if (beat_q == last_beat_q) begin
        valid_q <= 1'b0;
      end else begin
        beat_q     <= beat_q + 1'b1;
        fail_acc_q <= fail_acc_q | cur_fail;
      end
    end
  end

  assign out_valid_o = valid_q;
  assign status_o    = cur_st;
  assign byte_idx_o  = (cur_st == ST_FIXED) ? {beat_q, by_q[beat_q]} : '0;
  assign bit_idx_o   = bi_q[beat_q];
  assign last_o      = (beat_q == last_beat_q);
  assign fail_o      = fail_acc_q | cur_fail;

  // R7
  accept_to_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> out_valid_o);
  // R7
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o &&
      $stable({status_o, byte_idx_o, bit_idx_o, last_o, fail_o})));
  // R8
  single_last_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && !pair_mode_i) |=> last_o);
  // R9
  pair_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && pair_mode_i) |=> !last_o);
  // R6
  idx_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && status_o != ST_FIXED) |-> (byte_idx_o == '0 && bit_idx_o == '0));
  // R10
  fail_on_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && status_o[0]) |-> fail_o);
endmodule

// File: tb/sim_ecc_syndrome_check.sv
module sim_ecc_syndrome_check;
  localparam int CLK_PERIOD = 10;
  localparam logic [21:0] BASE = 22'h0F0F0F;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        in_valid = 1'b0, pair = 1'b0, out_ready = 1'b0;
  logic [43:0] calc = '0, stored = '0;
  logic        in_ready, out_valid, last, fail;
  logic [1:0]  status;
  logic [8:0]  byte_idx;
  logic [2:0]  bit_idx;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_syndrome_check u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .pair_mode_i(pair), .calc_i(calc), .stored_i(stored),
    .out_valid_o(out_valid), .out_ready_i(out_ready), .status_o(status),
    .byte_idx_o(byte_idx), .bit_idx_o(bit_idx), .last_o(last), .fail_o(fail)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic pm, input logic [43:0] c, input logic [43:0] s);
    @(negedge clk);
    pair = pm; calc = c; stored = s; in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  // expects {valid,status,byte,bit,last,fail}, then consumes the beat
  task automatic beat(input string req, input logic [1:0] st, input logic [8:0] by,
                      input logic [2:0] bi, input logic lst, input logic fl);
    @(negedge clk);
    check(req, {15'd0, out_valid, status, byte_idx, bit_idx, last, fail},
               {15'd0, 1'b1, st, by, bi, lst, fl});
    out_ready = 1'b1;
    @(posedge clk); #1;
    out_ready = 1'b0;
  endtask

  function automatic logic [21:0] fix_syn(input logic [10:0] p);
    return {~p, p};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R7 reset", {30'd0, out_valid, in_ready}, {30'd0, 1'b0, 1'b1});

    // R4 R1: every correctable location, junk in half 1 (R8)
    for (int p = 0; p < 2048; p++)
      begin
        send(1'b0, {22'h3FFFFF, BASE ^ fix_syn(11'(p))}, {22'h000001, BASE});
        beat("R4", 2'b10, 9'(p >> 3), 3'(p & 7), 1'b1, 1'b0);
      end

    // R3: single syndrome bit anywhere
    for (int k = 0; k < 22; k++) begin
      send(1'b0, {22'h0, BASE ^ (22'h1 << k)}, {22'h0, BASE});
      beat("R3", 2'b01, 9'd0, 3'd0, 1'b1, 1'b1);
    end

    // R2: equal codes, or either code zero
    send(1'b0, {22'h0, BASE}, {22'h0, BASE});
    beat("R2 equal", 2'b00, 9'd0, 3'd0, 1'b1, 1'b0);
    send(1'b0, {22'h0, 22'h0}, {22'h0, 22'h000008});
    beat("R2 calc zero", 2'b00, 9'd0, 3'd0, 1'b1, 1'b0);
    send(1'b0, {22'h0, 22'h1234AB}, {22'h0, 22'h0});
    beat("R2 stored zero", 2'b00, 9'd0, 3'd0, 1'b1, 1'b0);

    // R5: all two-bit syndromes
    for (int i = 0; i < 22; i++)
      for (int j = i + 1; j < 22; j++) begin
        send(1'b0, {22'h0, BASE ^ (22'h1 << i) ^ (22'h1 << j)}, {22'h0, BASE});
        beat("R5 two-bit", 2'b11, 9'd0, 3'd0, 1'b1, 1'b1);
      end
    // R5: eleven bits set, halves not complementary (R6 idx zero)
    send(1'b0, {22'h0, BASE ^ {11'h002, 11'h7FE}}, {22'h0, BASE});
    beat("R5 R6 eleven", 2'b11, 9'd0, 3'd0, 1'b1, 1'b1);

    // R7: backpressure, busy request dropped
    send(1'b0, {22'h0, BASE ^ fix_syn(11'h2C5)}, {22'h0, BASE});
    for (int w = 0; w < 3; w++) begin
      @(negedge clk);
      check("R7 hold", {20'd0, out_valid, in_ready, status, byte_idx},
                       {20'd0, 1'b1, 1'b0, 2'b10, 9'h58});
    end
    send(1'b0, {22'h0, BASE ^ 22'h1}, {22'h0, BASE});
    beat("R7 kept", 2'b10, 9'h58, 3'd5, 1'b1, 1'b0);
    @(negedge clk);
    check("R7 dropped", {31'd0, out_valid}, 32'd0);

    // R9 R10: pair mode, both halves correctable
    for (int p = 0; p < 2048; p += 97) begin
      send(1'b1, {BASE ^ fix_syn(11'(2047 - p)), BASE ^ fix_syn(11'(p))}, {BASE, BASE});
      beat("R9 first", 2'b10, 9'(p >> 3), 3'(p & 7), 1'b0, 1'b0);
      beat("R9 second", 2'b10, 9'(256 + ((2047 - p) >> 3)), 3'((2047 - p) & 7), 1'b1, 1'b0);
    end
    // R10: failing first, clean second keeps fail
    send(1'b1, {BASE, BASE ^ 22'h000003}, {BASE, BASE});
    beat("R10 first bad", 2'b11, 9'd0, 3'd0, 1'b0, 1'b1);
    beat("R10 carry", 2'b00, 9'd0, 3'd0, 1'b1, 1'b1);
    // R10: clean first, check-code error second
    send(1'b1, {BASE ^ 22'h200000, BASE}, {BASE, BASE});
    beat("R10 first clean", 2'b00, 9'd0, 3'd0, 1'b0, 1'b0);
    beat("R10 second err", 2'b01, 9'd0, 3'd0, 1'b1, 1'b1);
    // R8: after pair run, single mode returns one beat
    send(1'b0, {BASE ^ 22'h3, BASE}, {BASE, BASE});
    beat("R8 single", 2'b00, 9'd0, 3'd0, 1'b1, 1'b0);
    @(negedge clk);
    check("R8 one beat", {31'd0, out_valid}, 32'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule